// File: doc/BRIEF.md
# Class-Transition Issue Stall Controller

This block decides, each cycle, whether an in-order core must hold the instruction that is waiting to issue. It records the class of the last instruction that issued: multiply, divide, load, store or "other". It compares that class with the class of the waiting instruction. Together with the busy flags of the pipelined multiplier, the iterative divider and the load/store unit, that comparison produces one stall output. The logic is combinational apart from the one class register.

Back-to-back instructions of the same streaming class (multiply after multiply, load after load, store after store) pass without waiting, so a pipelined unit can accept one per cycle. A change of class waits for the previous unit to drain. A divide blocks issue for as long as the divider is busy, whatever comes next. The load/store unit can also raise a separate stall request, which always holds issue. Operand data hazards are handled by a separate scoreboard and are outside this block.

Top module: `issue_stall_ctrl`

## Requirements
- R1: When the last issued class is multiply and the waiting instruction is legal, not a NOP and not a multiply, `stall` equals `mul_busy`.
- R2: When the last issued class is multiply and the waiting instruction is a legal multiply, `mul_busy` has no effect on `stall`.
- R3: When the last issued class is divide, `stall` is high whenever `div_busy` is high, for any waiting instruction, including NOPs and illegal slots.
- R4: When the last issued class is load and the waiting instruction is legal, not a NOP and not a load, `stall` equals `lsu_busy`. A following load is not held by `lsu_busy`.
- R5: When the last issued class is store and the waiting instruction is legal, not a NOP and not a store, `stall` equals `lsu_busy`. A following store is not held by `lsu_busy`.
- R6: Only the rule for the recorded last class applies. The rules are checked in the order multiply, divide, load, store. Busy flags of other units have no effect on `stall`.
- R7: `lsu_stall_req` high forces `stall` high, regardless of class or busy flags.
- R8: `last_cls` updates to the waiting class on a clock edge where `next_legal` is high and `stall` is low. It holds while stalled or while no legal instruction waits. It clears to 0 on reset (`rst_n` low, asynchronous) and on `flush`, and `flush` takes priority over an issue in the same cycle.
- R9: A NOP (`next_nop` high) or an illegal slot (`next_legal` low) triggers none of the multiply, load or store transition stalls. An issued NOP records class 0.
- R10: Class codes on `next_cls` and `last_cls` are: 0 other, 1 multiply, 2 divide, 3 load, 4 store. Any other code is treated as class 0 and recorded as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; clears the recorded class |
| next_legal | input | 1 | A legal instruction waits to issue |
| next_nop | input | 1 | The waiting instruction is a NOP |
| next_cls | input | CLS_W | Class code of the waiting instruction |
| mul_busy | input | 1 | Multiplier still has work in flight |
| div_busy | input | 1 | Divider is iterating |
| lsu_busy | input | 1 | Load/store unit has work in flight |
| lsu_stall_req | input | 1 | Unconditional stall request from the load/store unit |
| stall | output | 1 | Hold the waiting instruction this cycle |
| last_cls | output | CLS_W | Class code of the most recently issued instruction |

## Verification
The assertions assume that a single agent drives the inputs at a stable point between clock edges, and that busy flags are meaningful only for the unit that last received work. They do not assume any link between the busy flags, so the stimulus raises flags of units that did not last issue, to show those flags are ignored. The stimulus always moves the recorded class through real issues, never by forcing it. It applies flush and reset both while idle and while a stall is pending. Each class-code pair is reached from a known recorded class, so the expected stall and next recorded class follow from the rules alone.

// File: rtl/isc_pkg.sv
package isc_pkg;

   typedef enum logic [2:0] {
      CLS_OTHER = 3'd0,
      CLS_MUL   = 3'd1,
      CLS_DIV   = 3'd2,
      CLS_LOAD  = 3'd3,
      CLS_STORE = 3'd4
   } iclass_e;

   // Map a raw 3-bit code onto a class; unknown codes fold to CLS_OTHER.
   function automatic iclass_e decode_cls(input logic [2:0] code);
      case (code)
         3'd1:    return CLS_MUL;
         3'd2:    return CLS_DIV;
         3'd3:    return CLS_LOAD;
         3'd4:    return CLS_STORE;
         default: return CLS_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/isc_class_reg.sv
module isc_class_reg
   import isc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    flush,
   input  logic    issue,
   input  iclass_e cls_in,
   output iclass_e cls_q
);

   // Recorded class of the last issued instruction (R8)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cls_q <= CLS_OTHER;
      else if (flush)  cls_q <= CLS_OTHER;
      else if (issue)  cls_q <= cls_in;
   end

endmodule

// File: rtl/isc_rules.sv
module isc_rules
   import isc_pkg::*;
#(
   parameter bit MUL_PIPELINED = 1'b1
)(
   input  iclass_e last_cls,
   input  iclass_e next_cls,
   input  logic    next_legal,
   input  logic    next_nop,
   input  logic    mul_busy,
   input  logic    div_busy,
   input  logic    lsu_busy,
   input  logic    lsu_stall_req,
   output logic    stall
);

   logic real_op;
   logic mul_match;
   logic rule_stall;

   // Only a legal, non-NOP instruction can trigger a transition rule (R9)
   assign real_op = next_legal & ~next_nop;

   generate
      if (MUL_PIPELINED) begin : g_mul_stream
         // Multiply followed by a different class waits (R1, R2)
         assign mul_match = (last_cls == CLS_MUL) & real_op & (next_cls != CLS_MUL);
      end else begin : g_mul_block
         // Non-pipelined multiplier: block like the divider
         assign mul_match = (last_cls == CLS_MUL);
      end
   endgenerate

   // First matching rule wins: multiply, divide, load, store (R6)
   always_comb begin
      rule_stall = 1'b0;
      if (mul_match) begin
         rule_stall = mul_busy;
      end else if (last_cls == CLS_DIV) begin
         rule_stall = div_busy;
      end else if ((last_cls == CLS_LOAD) & real_op & (next_cls != CLS_LOAD)) begin
         rule_stall = lsu_busy;
      end else if ((last_cls == CLS_STORE) & real_op & (next_cls != CLS_STORE)) begin
         rule_stall = lsu_busy;
      end
   end

   assign stall = rule_stall | lsu_stall_req;   // R7

endmodule

// File: rtl/issue_stall_ctrl.sv
module issue_stall_ctrl
   import isc_pkg::*;
#(
   parameter int CLS_W         = 3,
   parameter bit MUL_PIPELINED = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             next_legal,
   input  logic             next_nop,
   input  logic [CLS_W-1:0] next_cls,
   input  logic             mul_busy,
   input  logic             div_busy,
   input  logic             lsu_busy,
   input  logic             lsu_stall_req,
   output logic             stall,
   output logic [CLS_W-1:0] last_cls
);

   localparam int CODE_W = 3;

   if (CLS_W < CODE_W) begin : g_bad_width
      $error("issue_stall_ctrl: CLS_W must be at least 3");
   end

   logic        hi_clear;
   iclass_e     next_dec;
   iclass_e     rec_cls;
   iclass_e     cls_q;
   logic        issue;
   logic [2:0]  cls_bits;

   generate
      if (CLS_W > CODE_W) begin : g_wide
         assign hi_clear = ~|next_cls[CLS_W-1:CODE_W];
      end else begin : g_narrow
         assign hi_clear = 1'b1;
      end
   endgenerate

   // Unknown or out-of-range codes fold to class 0 (R10)
   assign next_dec = hi_clear ? decode_cls(next_cls[CODE_W-1:0]) : CLS_OTHER;
   // An issued NOP records class 0 (R9)
   assign rec_cls  = next_nop ? CLS_OTHER : next_dec;
   assign issue    = next_legal & ~stall;

   isc_class_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .issue  (issue),
      .cls_in (rec_cls),
      .cls_q  (cls_q)
   );

   isc_rules #(.MUL_PIPELINED(MUL_PIPELINED)) u_rules (
      .last_cls      (cls_q),
      .next_cls      (next_dec),
      .next_legal    (next_legal),
      .next_nop      (next_nop),
      .mul_busy      (mul_busy),
      .div_busy      (div_busy),
      .lsu_busy      (lsu_busy),
      .lsu_stall_req (lsu_stall_req),
      .stall         (stall)
   );

   assign cls_bits = cls_q;
   assign last_cls = CLS_W'(cls_bits);

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
   parameter int CLS_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             next_legal,
   input logic             next_nop,
   input logic [CLS_W-1:0] next_cls,
   input logic             mul_busy,
   input logic             div_busy,
   input logic             lsu_busy,
   input logic             lsu_stall_req,
   input logic             stall,
   input logic [CLS_W-1:0] last_cls
);

   localparam logic [CLS_W-1:0] K_MUL = CLS_W'(1);
   localparam logic [CLS_W-1:0] K_DIV = CLS_W'(2);

   AST_MUL_TO_OTHER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_cls == K_MUL && next_legal && !next_nop && next_cls != K_MUL && mul_busy) |-> stall); // R1

   AST_MUL_STREAM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (last_cls == K_MUL && next_legal && next_cls == K_MUL && !lsu_stall_req) |-> !stall); // R2

   AST_DIV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (last_cls == K_DIV && div_busy) |-> stall); // R3

   AST_LSU_REQ_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      lsu_stall_req |-> stall); // R7

   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !flush) |=> $stable(last_cls)); // R8

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (last_cls == '0)); // R8

   AST_IDLE_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!next_legal && last_cls != K_DIV && !lsu_stall_req) |-> !stall); // R9

   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (last_cls <= CLS_W'(4))); // R10

endmodule

bind issue_stall_ctrl isc_checker #(.CLS_W(CLS_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush         (flush),
   .next_legal    (next_legal),
   .next_nop      (next_nop),
   .next_cls      (next_cls),
   .mul_busy      (mul_busy),
   .div_busy      (div_busy),
   .lsu_busy      (lsu_busy),
   .lsu_stall_req (lsu_stall_req),
   .stall         (stall),
   .last_cls      (last_cls)
);

// File: tb/tb_issue_stall_ctrl.sv
module tb_issue_stall_ctrl;

   localparam int CLS_W = 3;

   typedef struct packed {
      logic       lg;
      logic       nop;
      logic [2:0] cls;
      logic       mb;
      logic       db;
      logic       lb;
      logic       ls;
      logic       fl;
      logic       st;
      logic [2:0] last;
      logic [3:0] req;
   } vec_t;

   function automatic vec_t mk(input logic lg, nop, input logic [2:0] cls,
                               input logic mb, db, lb, ls, fl, st,
                               input logic [2:0] last, input logic [3:0] req);
      return '{lg:lg, nop:nop, cls:cls, mb:mb, db:db, lb:lb, ls:ls, fl:fl,
               st:st, last:last, req:req};
   endfunction

   localparam int NV = 30;
   // Walked from reset (recorded class 0). Fields: legal, nop, class, mul/div/lsu busy,
   // lsu request, flush, expected stall, expected recorded class after the edge, requirement.
   localparam vec_t VEC [NV] = '{
      mk(1,0,1, 0,0,0,0,0, 0,1, 8),   // R8 multiply issues
      mk(1,0,1, 1,0,0,0,0, 0,1, 2),   // R2 multiply stream ignores busy
      mk(1,0,0, 1,0,0,0,0, 1,1, 1),   // R1 other waits on multiplier
      mk(1,1,0, 1,0,0,0,0, 0,0, 9),   // R9 NOP passes, records 0
      mk(1,0,2, 0,1,0,0,0, 0,2, 6),   // R6 divider busy ignored when last is 0
      mk(1,0,2, 0,1,0,0,0, 1,2, 3),   // R3 divide blocks
      mk(0,0,0, 0,1,0,0,0, 1,2, 3),   // R3 blocks even an empty slot
      mk(1,0,3, 0,0,0,0,0, 0,3, 4),   // R4 load issues
      mk(1,0,3, 0,0,1,0,0, 0,3, 4),   // R4 load stream
      mk(1,0,4, 0,0,1,0,0, 1,3, 4),   // R4 store after load waits
      mk(0,0,0, 0,0,1,0,0, 0,3, 9),   // R9 illegal slot no stall
      mk(1,0,4, 0,0,0,0,0, 0,4, 5),   // R5 store issues
      mk(1,0,4, 0,0,1,0,0, 0,4, 5),   // R5 store stream
      mk(1,0,3, 0,0,1,0,0, 1,4, 5),   // R5 load after store waits
      mk(1,0,3, 0,0,0,1,0, 1,4, 7),   // R7 request forces stall
      mk(1,0,0, 0,0,0,0,0, 0,0, 8),   // R8 other issues
      mk(1,0,0, 0,0,0,1,0, 1,0, 7),   // R7 request with class 0
      mk(1,0,1, 0,0,0,0,1, 0,0, 8),   // R8 flush beats issue
      mk(1,0,1, 0,0,0,0,0, 0,1, 8),   // R8 multiply issues
      mk(1,0,0, 0,1,1,0,0, 0,0, 6),   // R6 other units' busy ignored
      mk(1,0,2, 0,0,0,0,0, 0,2, 8),   // R8 divide issues
      mk(1,0,7, 0,0,0,0,0, 0,0, 10),  // R10 unknown code recorded as 0
      mk(1,0,3, 0,0,0,0,0, 0,3, 8),   // R8 load issues
      mk(1,1,0, 0,0,1,0,0, 0,0, 9),   // R9 NOP after load not held
      mk(1,0,1, 0,0,0,0,0, 0,1, 8),   // R8 multiply issues
      mk(1,0,0, 1,0,0,0,1, 1,0, 8),   // R8 flush while stalled clears
      mk(1,0,2, 0,0,0,0,0, 0,2, 8),   // R8 divide issues
      mk(1,0,0, 0,0,1,0,0, 0,0, 6),   // R6 lsu busy ignored after divide
      mk(1,0,2, 0,0,0,0,0, 0,2, 8),   // R8 divide issues
      mk(1,1,0, 0,1,0,0,0, 1,2, 3)    // R3 divide blocks a NOP
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             flush, next_legal, next_nop;
   logic [CLS_W-1:0] next_cls;
   logic             mul_busy, div_busy, lsu_busy, lsu_stall_req;
   logic             stall;
   logic [CLS_W-1:0] last_cls;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   issue_stall_ctrl #(.CLS_W(CLS_W)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .next_legal(next_legal),
      .next_nop(next_nop), .next_cls(next_cls), .mul_busy(mul_busy),
      .div_busy(div_busy), .lsu_busy(lsu_busy), .lsu_stall_req(lsu_stall_req),
      .stall(stall), .last_cls(last_cls)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      flush = 0; next_legal = 0; next_nop = 0; next_cls = '0;
      mul_busy = 0; div_busy = 0; lsu_busy = 0; lsu_stall_req = 0;
   endtask

   initial begin
      rst_n = 1'b0;
      idle();
      #1;
      check("R8 reset recorded class", 8'(last_cls), 8'd0);
      check("R8 reset stall", 8'(stall), 8'd0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         flush = VEC[i].fl; next_legal = VEC[i].lg; next_nop = VEC[i].nop;
         next_cls = VEC[i].cls; mul_busy = VEC[i].mb; div_busy = VEC[i].db;
         lsu_busy = VEC[i].lb; lsu_stall_req = VEC[i].ls;
         #1;
         check($sformatf("R%0d vec%0d stall", VEC[i].req, i), 8'(stall), 8'(VEC[i].st));
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec%0d last", VEC[i].req, i), 8'(last_cls), 8'(VEC[i].last));
      end

      // Directed R8: asynchronous reset clears a recorded divide mid-stall
      @(negedge clk);
      idle();
      div_busy = 1'b1;
      #1;
      check("R3 divide still blocking", 8'(stall), 8'd1);
      rst_n = 1'b0;
      #1;
      check("R8 async reset clears class", 8'(last_cls), 8'd0);
      check("R8 stall drops after reset", 8'(stall), 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      // Directed R1: multiplier idle lets a different class go
      next_legal = 1; next_cls = 3'd1;
      @(posedge clk);
      @(negedge clk);
      next_cls = 3'd3;
      #1;
      check("R1 multiplier idle no stall", 8'(stall), 8'd0);
      @(posedge clk);
      #1;
      check("R1 load recorded", 8'(last_cls), 8'd3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule